// File: doc/BRIEF.md
# Privilege Check and Trap Entry Unit

This unit judges each decoded instruction presented to it. It decides whether the instruction must be diverted into a program-check trap, and it produces the state that follows. An instruction traps in two cases. The first is a privileged operation issued while the machine-state register says the core is in problem (user) state. The second is an instruction that the decoder has flagged as illegal. Both faults redirect fetch to one fixed vector and save the faulting address and a copy of the machine state. The copy carries a single cause bit that tells the two faults apart. The live machine state is forced into a fixed supervisor configuration.

The unit is a small registered state machine. An instruction is presented with `in_valid` for one cycle. One cycle later the outputs show the verdict:
- **ST_IDLE**: no instruction was presented.
- **ST_SEQ**: the instruction proceeds sequentially. The next address is the current one plus 4 and register writes are allowed.
- **ST_TRAP**: a trap was taken. The vector replaces the next address, the save registers are loaded, and the instruction's own register writes are suppressed.

There are three transitions:
- **GO_SEQ**: `in_valid` is high and no fault is found.
- **GO_TRAP**: `in_valid` is high and a fault is found.
- **GO_IDLE**: `in_valid` is low.

Any state can take any of these transitions. Machine-state bit positions use big-endian numbering, where bit 0 is the MSB of the 64-bit word. Every position is a module parameter.

Top module: `trap_entry_unit`

## Requirements
- R1: Operation codes on `in_op` are: 0 other, 1 attention, 2 move-from-machine-state, 3 move-to-machine-state, 4 move-to-machine-state doubleword, 5 return-from-interrupt, 6 move-from-special-register, 7 move-to-special-register, 8 condition-field move. Codes 9 to 15 behave as 0. Codes 1 to 5 are privileged.
- R2: Codes 6 and 7 are privileged only when `in_spr_hi` is 1. With `in_spr_hi` at 0 they never cause a privilege trap.
- R3: A privileged operation traps exactly when the problem-state bit (big-endian bit 49 of `in_msr`) is 1.
- R4: `in_illegal` = 1 causes a trap whatever the problem state, except for code 8, where `in_illegal` is ignored.
- R5: On a trap `out_nia` equals TRAP_VEC (default 0x700). Otherwise it equals `in_cia` + 4 (modulo 2^64).
- R6: On a trap `out_srr0` takes `in_cia`. `out_srr1` takes `in_msr` with one cause bit set. The cause bit is big-endian bit 45 for a privilege fault and big-endian bit 44 for an illegal fault. When both faults apply, the privilege fault wins.
- R7: On a trap `out_msr` is `in_msr` with these big-endian bits cleared: 5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62. Bits 0 and 63 are set. All other bits, including both cause positions, are unchanged. Without a trap `out_msr` equals `in_msr`.
- R8: `out_srr0` and `out_srr1` change only in a cycle where `out_trap` is 1.
- R9: Results appear in the cycle after `in_valid`. `out_valid` is 1 in that cycle only. `out_trap` marks a trap. `out_wr_en` is 1 for a sequential result and 0 on a trap. `out_trap` and `out_wr_en` are never 1 together.
- R10: After reset `out_valid`, `out_trap` and `out_wr_en` are 0, and `out_nia`, `out_msr`, `out_srr0` and `out_srr1` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_op | input | 4 | Decoded operation code |
| in_spr_hi | input | 1 | High bit of the special-register number |
| in_illegal | input | 1 | Decoder flags the instruction as illegal |
| in_cia | input | 64 | Current instruction address |
| in_msr | input | 64 | Current machine-state register |
| out_valid | output | 1 | A verdict is shown this cycle |
| out_trap | output | 1 | The verdict is a trap |
| out_wr_en | output | 1 | The instruction's register writes may proceed |
| out_nia | output | 64 | Next instruction address |
| out_msr | output | 64 | New machine-state value |
| out_srr0 | output | 64 | Saved instruction address |
| out_srr1 | output | 64 | Saved machine state with cause bit |

## Verification
A privilege fault and an illegal fault can hit the same instruction in the same cycle. The bench provokes this by sweeping every operation code against every combination of the register-number high bit, the illegal flag and the problem-state bit. Each such result is judged on the cause bit in `out_srr1`: only the privilege position may be set, and the illegal position keeps its value from the machine state. The live `out_msr` is judged separately to confirm that neither cause position moved.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OPC_OTHER  = 4'd0,
        OPC_ATTN   = 4'd1,
        OPC_MFMS   = 4'd2,
        OPC_MTMS   = 4'd3,
        OPC_MTMSD  = 4'd4,
        OPC_RETINT = 4'd5,
        OPC_MFSR   = 4'd6,
        OPC_MTSR   = 4'd7,
        OPC_CRMOVE = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_TRAP = 2'd2
    } verdict_e;

endpackage

// File: rtl/trap_priv_classify.sv
module trap_priv_classify
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PR_BIT = 49
) (
    input  logic [OPW-1:0]  op,
    input  logic            spr_hi,
    input  logic            illegal,
    input  logic [XLEN-1:0] msr,
    output logic            fault,
    output logic            cause_priv
);
    localparam int PR_LE = XLEN - 1 - PR_BIT;

    logic    priv_op;
    logic    priv_fault;
    logic    ill_fault;
    opcode_e opc;

    always_comb begin
        opc = opcode_e'(op);
        priv_op = 1'b0;
        unique case (opc)
            OPC_ATTN, OPC_MFMS, OPC_MTMS, OPC_MTMSD, OPC_RETINT: priv_op = 1'b1;
            OPC_MFSR, OPC_MTSR: priv_op = spr_hi;
            default: priv_op = 1'b0;
        endcase
        priv_fault = priv_op && msr[PR_LE];
        ill_fault  = illegal && (opc != OPC_CRMOVE);
        fault      = priv_fault || ill_fault;
        cause_priv = priv_fault;
    end

endmodule

// File: rtl/trap_msr_xform.sv
module trap_msr_xform #(
    parameter int XLEN      = 64,
    parameter int SF_BIT    = 0,
    parameter int UND_BIT   = 5,
    parameter int TM_BIT    = 31,
    parameter int VEC_BIT   = 38,
    parameter int VSX_BIT   = 40,
    parameter int EE_BIT    = 48,
    parameter int PR_BIT    = 49,
    parameter int FP_BIT    = 50,
    parameter int FE0_BIT   = 52,
    parameter int TES_BIT   = 53,
    parameter int TEE_BIT   = 54,
    parameter int FE1_BIT   = 55,
    parameter int IR_BIT    = 58,
    parameter int DR_BIT    = 59,
    parameter int PMM_BIT   = 61,
    parameter int RI_BIT    = 62,
    parameter int LE_BIT    = 63,
    parameter int PRIV_BIT  = 45,
    parameter int ILLEG_BIT = 44
) (
    input  logic [XLEN-1:0] msr_in,
    input  logic            cause_priv,
    output logic [XLEN-1:0] msr_trap,
    output logic [XLEN-1:0] srr1_val
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    localparam logic [XLEN-1:0] CLR_MASK =
        (ONE << (XLEN-1-UND_BIT)) | (ONE << (XLEN-1-TM_BIT))  |
        (ONE << (XLEN-1-VEC_BIT)) | (ONE << (XLEN-1-VSX_BIT)) |
        (ONE << (XLEN-1-EE_BIT))  | (ONE << (XLEN-1-PR_BIT))  |
        (ONE << (XLEN-1-FP_BIT))  | (ONE << (XLEN-1-FE0_BIT)) |
        (ONE << (XLEN-1-TES_BIT)) | (ONE << (XLEN-1-TEE_BIT)) |
        (ONE << (XLEN-1-FE1_BIT)) | (ONE << (XLEN-1-IR_BIT))  |
        (ONE << (XLEN-1-DR_BIT))  | (ONE << (XLEN-1-PMM_BIT)) |
        (ONE << (XLEN-1-RI_BIT));

    localparam logic [XLEN-1:0] SET_MASK =
        (ONE << (XLEN-1-SF_BIT)) | (ONE << (XLEN-1-LE_BIT));

    localparam logic [XLEN-1:0] PRIV_MASK  = ONE << (XLEN-1-PRIV_BIT);
    localparam logic [XLEN-1:0] ILLEG_MASK = ONE << (XLEN-1-ILLEG_BIT);

    always_comb begin
        msr_trap = (msr_in & ~CLR_MASK) | SET_MASK;
        srr1_val = msr_in | (cause_priv ? PRIV_MASK : ILLEG_MASK);
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter logic [63:0]     TRAP_VEC  = 64'h700,
    parameter int              INSN_STEP = 4,
    parameter int              PR_BIT    = 49,
    parameter int              SF_BIT    = 0,
    parameter int              LE_BIT    = 63,
    parameter int              PRIV_BIT  = 45,
    parameter int              ILLEG_BIT = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      in_op,
    input  logic            in_spr_hi,
    input  logic            in_illegal,
    input  logic [63:0]     in_cia,
    input  logic [63:0]     in_msr,
    output logic            out_valid,
    output logic            out_trap,
    output logic            out_wr_en,
    output logic [63:0]     out_nia,
    output logic [63:0]     out_msr,
    output logic [63:0]     out_srr0,
    output logic [63:0]     out_srr1
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_STEP);

    verdict_e        state_q, state_d;
    logic            fault;
    logic            cause_priv;
    logic [XLEN-1:0] msr_trap;
    logic [XLEN-1:0] srr1_val;
    logic [XLEN-1:0] nia_q, msr_q, srr0_q, srr1_q;

    trap_priv_classify #(
        .XLEN   (XLEN),
        .PR_BIT (PR_BIT)
    ) u_classify (
        .op         (in_op),
        .spr_hi     (in_spr_hi),
        .illegal    (in_illegal),
        .msr        (in_msr),
        .fault      (fault),
        .cause_priv (cause_priv)
    );

    trap_msr_xform #(
        .XLEN      (XLEN),
        .SF_BIT    (SF_BIT),
        .PR_BIT    (PR_BIT),
        .LE_BIT    (LE_BIT),
        .PRIV_BIT  (PRIV_BIT),
        .ILLEG_BIT (ILLEG_BIT)
    ) u_xform (
        .msr_in     (in_msr),
        .cause_priv (cause_priv),
        .msr_trap   (msr_trap),
        .srr1_val   (srr1_val)
    );

    // next-state decision: GO_IDLE / GO_SEQ / GO_TRAP
    always_comb begin
        unique case ({in_valid, fault})
            2'b10:   state_d = ST_SEQ;
            2'b11:   state_d = ST_TRAP;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nia_q  <= '0;
            msr_q  <= '0;
            srr0_q <= '0;
            srr1_q <= '0;
        end else begin
            unique case (state_d)
                ST_TRAP: begin
                    nia_q  <= TRAP_VEC[XLEN-1:0];
                    msr_q  <= msr_trap;
                    srr0_q <= in_cia;
                    srr1_q <= srr1_val;
                end
                ST_SEQ: begin
                    nia_q <= in_cia + STEP;
                    msr_q <= in_msr;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        out_valid = (state_q != ST_IDLE);
        out_trap  = (state_q == ST_TRAP);
        out_wr_en = (state_q == ST_SEQ);
        out_nia   = nia_q;
        out_msr   = msr_q;
        out_srr0  = srr0_q;
        out_srr1  = srr1_q;
    end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter logic [63:0] TRAP_VEC  = 64'h700,
    parameter int          PR_BIT    = 49,
    parameter int          SF_BIT    = 0,
    parameter int          LE_BIT    = 63,
    parameter int          PRIV_BIT  = 45,
    parameter int          ILLEG_BIT = 44
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_cia,
    input logic [63:0] in_msr,
    input logic        out_valid,
    input logic        out_trap,
    input logic        out_wr_en,
    input logic [63:0] out_nia,
    input logic [63:0] out_msr,
    input logic [63:0] out_srr0,
    input logic [63:0] out_srr1
);
    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_nia == TRAP_VEC) else $error("vector"); // R5
    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_trap) |-> out_nia == $past(in_cia) + 64'd4) else $error("seq"); // R5
    AST_SRR0_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_srr0 == $past(in_cia)) else $error("srr0"); // R6
    AST_CAUSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_srr1[63-PRIV_BIT] || out_srr1[63-ILLEG_BIT])) else $error("cause"); // R6
    AST_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (!out_msr[63-PR_BIT] && out_msr[63-SF_BIT] && out_msr[63-LE_BIT])) else $error("msr"); // R7
    AST_CAUSE_NOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_msr[63-PRIV_BIT] == $past(in_msr[63-PRIV_BIT]))) else $error("live"); // R7
    AST_SRR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_trap |-> ($stable(out_srr0) && $stable(out_srr1))) else $error("hold"); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid"); // R9
    AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_trap && out_wr_en)) else $error("excl"); // R9
endmodule

bind trap_entry_unit trap_entry_chk #(
    .TRAP_VEC  (TRAP_VEC),
    .PR_BIT    (PR_BIT),
    .SF_BIT    (SF_BIT),
    .LE_BIT    (LE_BIT),
    .PRIV_BIT  (PRIV_BIT),
    .ILLEG_BIT (ILLEG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cia    (in_cia),
    .in_msr    (in_msr),
    .out_valid (out_valid),
    .out_trap  (out_trap),
    .out_wr_en (out_wr_en),
    .out_nia   (out_nia),
    .out_msr   (out_msr),
    .out_srr0  (out_srr0),
    .out_srr1  (out_srr1)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_spr_hi = 1'b0;
    logic        in_illegal = 1'b0;
    logic [63:0] in_cia = '0;
    logic [63:0] in_msr = '0;
    logic        out_valid, out_trap, out_wr_en;
    logic [63:0] out_nia, out_msr, out_srr0, out_srr1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_spr_hi(in_spr_hi), .in_illegal(in_illegal), .in_cia(in_cia),
        .in_msr(in_msr), .out_valid(out_valid), .out_trap(out_trap),
        .out_wr_en(out_wr_en), .out_nia(out_nia), .out_msr(out_msr),
        .out_srr0(out_srr0), .out_srr1(out_srr1)
    );

    function automatic logic [63:0] bb(input int n);
        return 64'd1 << (63 - n);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [63:0] m_srr0 = '0, m_srr1 = '0;

    task automatic run_case(input int op, input bit hi, input bit ill,
                            input logic [63:0] cia, input logic [63:0] msr);
        bit privop, pfault, ifault, trap;
        logic [63:0] clr, exp_msr;
        privop = (op >= 1 && op <= 5) || ((op == 6 || op == 7) && hi);
        pfault = privop && msr[63-49];
        ifault = ill && (op != 8);
        trap   = pfault || ifault;
        clr = bb(5)|bb(31)|bb(38)|bb(40)|bb(48)|bb(49)|bb(50)|bb(52)|
              bb(53)|bb(54)|bb(55)|bb(58)|bb(59)|bb(61)|bb(62);
        exp_msr = trap ? ((msr & ~clr) | bb(0) | bb(63)) : msr;
        if (trap) begin
            m_srr0 = cia;
            m_srr1 = msr | (pfault ? bb(45) : bb(44));
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'(op); in_spr_hi = hi; in_illegal = ill;
        in_cia = cia; in_msr = msr;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 R2 R3 R4 trap", {63'd0, out_trap}, {63'd0, trap});
        chk("R9 valid", {63'd0, out_valid}, 64'd1);
        chk("R9 wr_en", {63'd0, out_wr_en}, {63'd0, !trap});
        chk("R5 nia", out_nia, trap ? 64'h700 : cia + 64'd4);
        chk("R7 msr", out_msr, exp_msr);
        chk("R6 R8 srr0", out_srr0, m_srr0);
        chk("R6 R8 srr1", out_srr1, m_srr1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid", {63'd0, out_valid}, 64'd0);
        chk("R10 trap", {63'd0, out_trap}, 64'd0);
        chk("R10 wr_en", {63'd0, out_wr_en}, 64'd0);
        chk("R10 nia", out_nia, 64'd0);
        chk("R10 msr", out_msr, 64'd0);
        chk("R10 srr0", out_srr0, 64'd0);
        chk("R10 srr1", out_srr1, 64'd0);
        for (int k = 0; k < 2; k++) begin
            for (int op = 0; op < 16; op++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [63:0] cia, msr;
                    int n;
                    n = k*128 + op*8 + v;
                    cia = {32'(n) * 32'h9E3779B9, 32'(n) * 32'h10} | 64'hFFFF_FFF0_0000_0000 * k;
                    msr = {32'(n) * 32'h7F4A7C15, ~(32'(n) * 32'h85EBCA6B)};
                    if (k == 1) msr = ~msr;
                    msr[63-49] = v[0];
                    run_case(op, v[1], v[2], cia, msr);
                    // idle cycle: no new verdict, save registers hold (R8, R9)
                    @(negedge clk);
                    chk("R9 idle", {63'd0, out_valid}, 64'd0);
                    chk("R8 idle srr0", out_srr0, m_srr0);
                end
            end
        end
        // wrap of address increment (R5)
        run_case(0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0);
        // code 8 ignores illegal even in problem state (R4)
        run_case(8, 1'b1, 1'b1, 64'h1234, bb(49));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule